// File: doc/BRIEF.md
# Banked Register-Window I2C Target

This block is an I2C target that answers on two 7-bit device addresses. The main address exposes a 256-byte window. Offsets 00h–7Fh always reach a fixed register area. Offsets 80h–FFh reach one of several 128-byte tables. A selector byte held in the register area picks the table. The second address reaches a flat 256-byte auxiliary store that has no banking.

The controller keeps one byte pointer per device address. A write transaction sends a memory-address byte and then data bytes. Each data byte lands at the pointer, and the pointer then steps within its 8-byte row. A read with no address phase starts at the current pointer. A random read is formed from an address-only write, a repeated START and a read.

Writes to protected tables depend on a password level. That level is found by comparing a 4-byte entry field in the register area against two stored passwords kept in table 02h. A write that lacks the needed level is still acknowledged, but its data is dropped. SCL and SDA are oversampled in the system clock domain. The block drives SDA low through an active-high enable.

Top module: `regmem_i2c_slave`

## Requirements
- R1: The target acknowledges only device addresses 51h (main window) and 50h (auxiliary store). Any other address gets a NACK, after which the target drives nothing and stores nothing until the next START.
- R2: Offsets 00h–7Fh of the main window reach the register area whatever the selector byte holds.
- R3: Offsets 80h–FFh of the main window reach the table numbered by the selector byte at offset 7Fh. With a selector of 9 or more, reads return 00h and writes are dropped.
- R4: During a write, the pointer steps only through the lowest 3 bits, so consecutive data bytes wrap inside one 8-byte row.
- R5: A read with no address phase starts at the current pointer. Every byte read advances the main pointer within its half: FFh goes to 80h, and 7Fh goes to 00h.
- R6: An address-only write followed by a repeated START and a read returns data starting at the address that was sent.
- R7: After the controller NACKs a read byte, the target releases SDA and ignores further clocks until a START. The pointer does not move because of those clocks.
- R8: The entry field sits at offsets 7Bh–7Eh, with 7Bh paired to the first password byte. If it matches the second password (table 02h offsets 84h–87h), the level is 2. If it matches the first password (offsets 80h–83h), the level is 1. Otherwise the level is 0. Both passwords reset to FFh bytes.
- R9: Writes to table 01h need level 1 or more. Writes to tables 02h–08h need level 2. Writes that fail this test are acknowledged and discarded.
- R10: The auxiliary store is a flat 256 bytes with its own pointer. Reads wrap that pointer from FFh to 00h, and writes wrap within an 8-byte row.
- R11: The target starts driving SDA low only while SCL is low.
- R12: After reset, SDA is released, both pointers are 00h, the register area is all 00h and the selector is table 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (open-drain enable) |

## Verification
The bound checker watches, on every cycle, four things:
- SDA is only ever asserted while SCL is low.
- A START always returns the receiver to its first bit.
- Every accepted table write meets the required password level.
- Neither pointer leaves its row during a write or its half during a main-window read.

The bench's transaction scenarios are needed for everything that depends on data values: bank selection, discarded writes, the password comparisons, random reads, the auxiliary store, and the silence that follows a NACK or a foreign address. Its reference memory model compares every byte read and every acknowledge bit.

// File: rtl/regmem_pkg.sv
// Shared types, map constants and pointer-step helpers for the banked
// register-window I2C target. Assumes a 256-byte window split into halves.
package regmem_pkg;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_st_t;
    typedef enum logic [1:0] {K_DEV, K_MADDR, K_DATA} rx_kind_t;

    localparam int          ROW_BITS   = 3;       // 8-byte write rows
    localparam int          HALF       = 128;     // bytes per half / per table
    localparam logic [6:0]  SEL_OFS    = 7'h7F;   // table selector offset
    localparam int          ENTRY_BASE = 'h7B;    // password entry field start
    localparam int          PW_BYTES   = 4;
    localparam int          PW_TABLE   = 2;       // table holding stored passwords
    localparam int          PW1_OFS    = 0;
    localparam int          PW2_OFS    = 4;
    localparam int          L1_TABLE   = 1;
    localparam int          L2_FIRST   = 2;
    localparam int          L2_LAST    = 8;

    // Pointer step after a written byte: wrap inside the 8-byte row
    function automatic logic [7:0] step_wr(input logic [7:0] p);
        logic [7:0] n;
        n = p;
        n[ROW_BITS-1:0] = p[ROW_BITS-1:0] + 1'b1;
        return n;
    endfunction

    // Main-window step after a read byte: wrap inside the current half
    function automatic logic [7:0] step_rd_main(input logic [7:0] p);
        logic [7:0] n;
        n = p;
        n[6:0] = p[6:0] + 1'b1;
        return n;
    endfunction

    // Password level a table demands for writes
    function automatic logic [1:0] need_level(input logic [7:0] sel);
        if (int'(sel) == L1_TABLE)
            return 2'd1;
        else if (int'(sel) >= L2_FIRST && int'(sel) <= L2_LAST)
            return 2'd2;
        else
            return 2'd0;
    endfunction

endpackage

// File: rtl/regmem_line_sync.sv
// Brings SCL/SDA into the clock domain and flags edges, START and STOP.
// Assumes the bus is slower than a few clk cycles per SCL phase.
module regmem_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_q, sda_q;
    logic scl_p, sda_p;

    // Shift chain: synchroniser stages plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    assign scl_s    = scl_q[DEPTH-2];
    assign sda_s    = sda_q[DEPTH-2];
    assign scl_p    = scl_q[DEPTH-1];
    assign sda_p    = sda_q[DEPTH-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/regmem_pw_level.sv
// Derives the current password level from the entry field and the two
// stored passwords. A level-2 match wins over a level-1 match.
module regmem_pw_level #(
    parameter int PW_W = 32
) (
    input  logic [PW_W-1:0] entry,
    input  logic [PW_W-1:0] pw_one,
    input  logic [PW_W-1:0] pw_two,
    output logic [1:0]      level
);
    // Priority compare: level 2 implies level 1
    always_comb begin
        if (entry == pw_two)
            level = 2'd2;
        else if (entry == pw_one)
            level = 2'd1;
        else
            level = 2'd0;
    end
endmodule

// File: rtl/regmem_store.sv
// Behavioural storage: register area, banked tables and auxiliary store.
// Assumes the caller has already applied password gating to wr_en.
module regmem_store
    import regmem_pkg::*;
#(
    parameter int NUM_TABLES = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    acc_aux,
    input  logic [7:0]              addr,
    input  logic [7:0]              wr_data,
    output logic [7:0]              rd_data,
    output logic [7:0]              tbl_sel,
    output logic [8*PW_BYTES-1:0]   pw_entry,
    output logic [8*PW_BYTES-1:0]   pw_one,
    output logic [8*PW_BYTES-1:0]   pw_two
);
    localparam int TBL_CELLS = NUM_TABLES * HALF;
    localparam int IDX_W     = $clog2(TBL_CELLS);
    localparam int PW_LO     = PW_TABLE * HALF;
    localparam int PW_HI     = PW_LO + PW2_OFS + PW_BYTES;

    logic [7:0] lo_mem  [HALF];
    logic [7:0] tb_mem  [TBL_CELLS];
    logic [7:0] aux_mem [256];
    logic             tbl_ok;
    logic [IDX_W-1:0] tb_idx;

    assign tbl_sel = lo_mem[SEL_OFS];
    assign tbl_ok  = int'(tbl_sel) < NUM_TABLES;
    assign tb_idx  = IDX_W'(int'(tbl_sel) * HALF + int'(addr[6:0]));

    // Storage update; stored passwords come out of reset as all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++)
                lo_mem[i[6:0]] <= 8'h00;
            for (int i = 0; i < TBL_CELLS; i++)
                tb_mem[IDX_W'(i)] <= (i >= PW_LO && i < PW_HI) ? 8'hFF : 8'h00;
            for (int i = 0; i < 256; i++)
                aux_mem[i[7:0]] <= 8'h00;
        end else if (wr_en) begin
            if (acc_aux)
                aux_mem[addr] <= wr_data;
            else if (!addr[7])
                lo_mem[addr[6:0]] <= wr_data;
            else if (tbl_ok)
                tb_mem[tb_idx] <= wr_data;
        end
    end

    // Read mux; an unpopulated table reads as zero
    always_comb begin
        if (acc_aux)
            rd_data = aux_mem[addr];
        else if (!addr[7])
            rd_data = lo_mem[addr[6:0]];
        else if (tbl_ok)
            rd_data = tb_mem[tb_idx];
        else
            rd_data = 8'h00;
    end

    // Expose password entry and stored passwords byte by byte
    for (genvar g = 0; g < PW_BYTES; g++) begin : g_pw
        assign pw_entry[8*g +: 8] = lo_mem[7'(ENTRY_BASE + g)];
        assign pw_one[8*g +: 8]   = tb_mem[IDX_W'(PW_LO + PW1_OFS + g)];
        assign pw_two[8*g +: 8]   = tb_mem[IDX_W'(PW_LO + PW2_OFS + g)];
    end

endmodule

// File: rtl/regmem_i2c_slave.sv
// Top: I2C target with a banked upper half, row-wrapped writes, per-table
// password gating and a second flat device address. Assumes 7-bit
// addressing and no clock stretching.
module regmem_i2c_slave
    import regmem_pkg::*;
#(
    parameter logic [6:0] MAIN_DEV    = 7'h51,
    parameter logic [6:0] AUX_DEV     = 7'h50,
    parameter int         NUM_TABLES  = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PW_W = 8 * PW_BYTES;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    bus_st_t    st;
    rx_kind_t   kind;
    logic [3:0] cnt;
    logic [7:0] rx_sreg, tx_sreg, ptr_main, ptr_aux, cur_ptr, rd_data, tbl_sel;
    logic       is_aux, is_read, mack;
    logic [PW_W-1:0] pw_entry, pw_one, pw_two;
    logic [1:0] level, req_level;
    logic       byte_done, dev_hit, tx_load, wr_ok, wr_en;

    regmem_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    regmem_store #(.NUM_TABLES(NUM_TABLES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_aux(is_aux),
        .addr(cur_ptr), .wr_data(rx_sreg), .rd_data(rd_data), .tbl_sel(tbl_sel),
        .pw_entry(pw_entry), .pw_one(pw_one), .pw_two(pw_two)
    );

    regmem_pw_level #(.PW_W(PW_W)) u_pw (
        .entry(pw_entry), .pw_one(pw_one), .pw_two(pw_two), .level(level)
    );

    // Transaction decode and write gating
    assign cur_ptr   = is_aux ? ptr_aux : ptr_main;
    assign byte_done = (st == ST_RX) && scl_fall && (cnt == 4'd8);
    assign dev_hit   = (rx_sreg[7:1] == MAIN_DEV) || (rx_sreg[7:1] == AUX_DEV);
    assign tx_load   = scl_fall && (((st == ST_RX_ACK) && is_read) ||
                                    ((st == ST_TX_ACK) && mack));
    assign req_level = need_level(tbl_sel);
    assign wr_ok     = is_aux || !cur_ptr[7] || (level >= req_level);
    assign wr_en     = byte_done && (kind == K_DATA) && wr_ok;

    // Open-drain drive: ACK slot or a zero data bit
    assign sda_oe = (st == ST_RX_ACK) || ((st == ST_TX) && !tx_sreg[7]);

    // Bus sequencer: receive, acknowledge, transmit, pointer upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= K_DEV;
            cnt      <= '0;
            rx_sreg  <= '0;
            tx_sreg  <= '1;
            ptr_main <= '0;
            ptr_aux  <= '0;
            is_aux   <= 1'b0;
            is_read  <= 1'b0;
            mack     <= 1'b0;
        end else if (start_ev) begin
            st   <= ST_RX;
            kind <= K_DEV;
            cnt  <= '0;
        end else if (stop_ev) begin
            st <= ST_IDLE;
        end else if (tx_load) begin
            st      <= ST_TX;
            cnt     <= '0;
            tx_sreg <= rd_data;
            if (is_aux) ptr_aux  <= ptr_aux + 8'd1;
            else        ptr_main <= step_rd_main(ptr_main);
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && cnt != 4'd8) begin
                        rx_sreg <= {rx_sreg[6:0], sda_s};
                        cnt     <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        st  <= ST_RX_ACK;
                        case (kind)
                            K_DEV: begin
                                is_aux  <= (rx_sreg[7:1] == AUX_DEV);
                                is_read <= rx_sreg[0];
                                if (!dev_hit) st <= ST_IDLE;
                            end
                            K_MADDR: begin
                                if (is_aux) ptr_aux  <= rx_sreg;
                                else        ptr_main <= rx_sreg;
                            end
                            default: begin
                                if (is_aux) ptr_aux  <= step_wr(ptr_aux);
                                else        ptr_main <= step_wr(ptr_main);
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        st   <= ST_RX;
                        cnt  <= '0;
                        kind <= (kind == K_DEV) ? K_MADDR : K_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            st <= ST_TX_ACK;
                        end else begin
                            tx_sreg <= {tx_sreg[6:0], 1'b1};
                            cnt     <= cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) st <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regmem_chk.sv
// Property checker bound into the top; observes internal state only.
module regmem_chk
    import regmem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       start_ev,
    input bus_st_t    st,
    input logic [3:0] cnt,
    input logic       wr_en,
    input logic       is_aux,
    input logic [7:0] cur_ptr,
    input logic [1:0] level,
    input logic [1:0] req_level,
    input logic [7:0] ptr_main,
    input logic [7:0] ptr_aux,
    input logic       tx_load
);
    // R11
    drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R1
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st == ST_RX && cnt == 4'd0));

    // R9
    table_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_aux && cur_ptr[7]) |-> (level >= req_level));

    // R4
    main_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_aux) |=> (ptr_main[7:3] == $past(ptr_main[7:3])));

    // R10
    aux_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_aux) |=> (ptr_aux[7:3] == $past(ptr_aux[7:3])));

    // R5
    half_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !is_aux) |=> (ptr_main[7] == $past(ptr_main[7])));

endmodule

bind regmem_i2c_slave regmem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .start_ev(start_ev), .st(st), .cnt(cnt), .wr_en(wr_en),
    .is_aux(is_aux), .cur_ptr(cur_ptr), .level(level), .req_level(req_level),
    .ptr_main(ptr_main), .ptr_aux(ptr_aux), .tx_load(tx_load)
);

// File: tb/test_regmem_i2c_slave.sv
// Bench: bit-level bus driver plus a behavioural memory model of the
// requirements; every byte and acknowledge is compared with the model.
module test_regmem_i2c_slave;
    localparam int Q  = 10;   // clk cycles per quarter SCL period
    localparam int NT = 9;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;
    int   checks = 0, failures = 0;
    bit   done = 0, quiet = 0, quiet_bad = 0, r11_bad = 0, prev_oe = 0;

    logic [7:0] m_lo [128];
    logic [7:0] m_tb [NT*128];
    logic [7:0] m_aux[256];
    logic [7:0] p_main = 8'h00, p_aux = 8'h00;
    logic [7:0] wbuf[$];

    always #4 clk = ~clk;

    regmem_i2c_slave i_regmem_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe && !prev_oe && scl) r11_bad = 1;
            if (quiet && sda_oe) quiet_bad = 1;
            prev_oe = sda_oe;
        end
    end

    // ---------------- reference model ----------------
    function automatic int m_level();
        bit e2 = 1, e1 = 1;
        for (int i = 0; i < 4; i++) begin
            if (m_lo[8'h7B + i] != m_tb[256 + 4 + i]) e2 = 0;
            if (m_lo[8'h7B + i] != m_tb[256 + i])     e1 = 0;
        end
        return e2 ? 2 : (e1 ? 1 : 0);
    endfunction

    function automatic logic [7:0] m_rd(input bit aux, input logic [7:0] a);
        int sel = m_lo[127];
        if (aux) return m_aux[a];
        if (a < 128) return m_lo[a[6:0]];
        if (sel >= NT) return 8'h00;
        return m_tb[sel*128 + int'(a) - 128];
    endfunction

    task automatic m_wr(input bit aux, input logic [7:0] a, input logic [7:0] d);
        int sel = m_lo[127];
        int need;
        if (aux) begin m_aux[a] = d; return; end
        if (a < 128) begin m_lo[a[6:0]] = d; return; end
        need = (sel == 1) ? 1 : ((sel >= 2 && sel <= 8) ? 2 : 0);
        if (sel < NT && m_level() >= need) m_tb[sel*128 + int'(a) - 128] = d;
    endtask

    function automatic logic [7:0] inc_wr(input logic [7:0] a);
        return (a & 8'hF8) | ((a + 8'd1) & 8'h07);
    endfunction

    // ---------------- bus driver ----------------
    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq();
    endtask

    task automatic bit_clk(input logic b, output logic r);
        sda_m = b; wq(); scl = 1; wq(); r = sda_line; wq(); scl = 0; wq();
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_clk(v[i], r);
        bit_clk(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv(input logic mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin bit_clk(1'b1, r); v[i] = r; end
        bit_clk(~mack, r);
    endtask

    function automatic logic [6:0] dev(input bit aux);
        return aux ? 7'h50 : 7'h51;
    endfunction

    // Write transaction: address byte then bytes from wbuf
    task automatic do_write(input string tag, input bit aux, input logic [7:0] addr);
        logic ack;
        logic [7:0] p;
        bus_start();
        send({dev(aux), 1'b0}, ack); chk("R1 device ack", ack, 1);
        send(addr, ack);             chk({tag, " addr ack"}, ack, 1);
        p = addr;
        foreach (wbuf[i]) begin
            send(wbuf[i], ack);
            chk({tag, " data ack"}, ack, 1);
            m_wr(aux, p, wbuf[i]);
            p = inc_wr(p);
        end
        if (aux) p_aux = p; else p_main = p;
        bus_stop();
        wbuf.delete();
    endtask

    // Read n bytes: random (address phase + repeated START) or current-address
    task automatic do_read(input string tag, input bit aux, input int n,
                           input bit rnd, input logic [7:0] addr);
        logic ack;
        logic [7:0] v, p;
        bus_start();
        if (rnd) begin
            send({dev(aux), 1'b0}, ack); chk("R1 device ack", ack, 1);
            send(addr, ack);             chk({tag, " addr ack"}, ack, 1);
            if (aux) p_aux = addr; else p_main = addr;
            bus_start();
        end
        send({dev(aux), 1'b1}, ack); chk("R1 device ack", ack, 1);
        p = aux ? p_aux : p_main;
        for (int k = 0; k < n; k++) begin
            recv(k != n - 1, v);
            chk(tag, v, m_rd(aux, p));
            p = aux ? p + 8'd1 : ((p & 8'h80) | ((p + 8'd1) & 8'h7F));
        end
        if (aux) p_aux = p; else p_main = p;
        bus_stop();
    endtask

    task automatic put1(input logic [7:0] a);
        wbuf.push_back(a);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        logic r;
        for (int i = 0; i < 128; i++) m_lo[i] = 8'h00;
        for (int i = 0; i < NT*128; i++) m_tb[i] = (i >= 256 && i < 264) ? 8'hFF : 8'h00;
        for (int i = 0; i < 256; i++) m_aux[i] = 8'h00;

        repeat (5) @(negedge clk);
        chk("R12 sda released in reset", sda_oe, 0);
        rst_n = 1;
        wq();

        // R12: reset contents and pointers via current-address reads
        do_read("R12 main reset read", 0, 2, 0, 8'h00);
        do_read("R12 aux reset read", 1, 1, 0, 8'h00);
        do_read("R12 selector reset", 0, 1, 1, 8'h7F);

        // R1: foreign address is NACKed and the bus is ignored
        bus_start();
        quiet = 1; quiet_bad = 0;
        send({7'h33, 1'b0}, ack); chk("R1 foreign nack", ack, 0);
        send(8'h10, ack);          chk("R1 ignored byte nack", ack, 0);
        send(8'hAA, ack);          chk("R1 ignored byte nack", ack, 0);
        bus_stop();
        quiet = 0;
        chk("R1 no drive after foreign address", quiet_bad, 0);
        do_read("R1 nothing stored", 0, 1, 1, 8'h10);

        // R2: lower area unaffected by selector
        put1(8'h21); put1(8'h22); put1(8'h23);
        do_write("R2", 0, 8'h20);
        put1(8'h03); do_write("R2 select 3", 0, 8'h7F);
        do_read("R2 lower with table 3", 0, 3, 1, 8'h20);

        // R4 + R6: 10-byte write from 15h wraps in row 10h-17h
        for (int i = 0; i < 10; i++) put1(8'hA0 + 8'(i));
        do_write("R4", 0, 8'h15);
        do_read("R4 row wrap readback", 0, 8, 1, 8'h10);
        do_read("R6 random read", 0, 1, 1, 8'h16);
        chk("R4 literal byte at 10h", m_lo[16], 8'hA3);

        // R3: table 0 open, out-of-range table reads zero, drops writes
        put1(8'h00); do_write("R3 select 0", 0, 8'h7F);
        put1(8'h5A); put1(8'h5B); do_write("R3", 0, 8'h90);
        do_read("R3 table 0", 0, 2, 1, 8'h90);
        put1(8'h09); do_write("R3 select 9", 0, 8'h7F);
        put1(8'h77); do_write("R3 out of range", 0, 8'h90);
        do_read("R3 out of range reads zero", 0, 2, 1, 8'h90);
        put1(8'h00); do_write("R3 select 0", 0, 8'h7F);
        do_read("R3 table 0 kept", 0, 2, 1, 8'h90);
        chk("R3 literal", m_tb[16], 8'h5A);

        // R9: protected tables reject writes at level 0
        put1(8'h01); do_write("R9 select 1", 0, 8'h7F);
        put1(8'h66); do_write("R9 level0 table1", 0, 8'h80);
        do_read("R9 table1 unchanged", 0, 1, 1, 8'h80);
        put1(8'h03); do_write("R9 select 3", 0, 8'h7F);
        put1(8'h67); do_write("R9 level0 table3", 0, 8'h88);
        do_read("R9 table3 unchanged", 0, 1, 1, 8'h88);

        // R8: entry of all FFh matches PW2 reset value -> level 2
        for (int i = 0; i < 4; i++) put1(8'hFF);
        do_write("R8 entry ff", 0, 8'h7B);
        chk("R8 model level 2", m_level(), 2);
        put1(8'h68); do_write("R8 level2 table3", 0, 8'h88);
        do_read("R8 table3 written", 0, 1, 1, 8'h88);
        put1(8'h02); do_write("R8 select 2", 0, 8'h7F);
        put1(8'h11); put1(8'h22); put1(8'h33); put1(8'h44);
        do_write("R8 set pw1", 0, 8'h80);
        do_read("R8 pw1 stored", 0, 4, 1, 8'h80);
        put1(8'h11); put1(8'h22); put1(8'h33); put1(8'h44);
        do_write("R8 entry pw1", 0, 8'h7B);
        chk("R8 model level 1", m_level(), 1);
        put1(8'h01); do_write("R9 select 1", 0, 8'h7F);
        put1(8'h69); do_write("R9 level1 table1", 0, 8'h80);
        do_read("R9 table1 written", 0, 1, 1, 8'h80);
        put1(8'h03); do_write("R9 select 3", 0, 8'h7F);
        put1(8'h6A); do_write("R9 level1 table3", 0, 8'h88);
        do_read("R9 table3 still 68", 0, 1, 1, 8'h88);

        // R5: half wraps on reads and current-address continuation
        do_read("R5 upper wrap", 0, 3, 1, 8'hFE);
        do_read("R5 lower wrap", 0, 3, 1, 8'h7E);
        do_read("R5 current address", 0, 2, 0, 8'h00);
        chk("R5 pointer model", p_main, 8'h03);

        // R10: auxiliary store flat, own pointer, row wrap on write
        put1(8'hC1); put1(8'hC2); put1(8'hC3);
        do_write("R10", 1, 8'hFE);
        do_read("R10 aux wrap read", 1, 2, 1, 8'hFF);
        do_read("R10 aux row start", 1, 1, 1, 8'hF8);
        do_read("R10 main pointer untouched", 0, 1, 0, 8'h00);

        // R7: after NACK the target stays silent until START
        bus_start();
        send({7'h51, 1'b1}, ack); chk("R1 device ack", ack, 1);
        recv(1'b0, v);
        chk("R7 byte before nack", v, m_rd(0, p_main));
        p_main = (p_main & 8'h80) | ((p_main + 8'd1) & 8'h7F);
        quiet = 1; quiet_bad = 0;
        for (int i = 0; i < 9; i++) begin
            bit_clk(1'b1, r);
            chk("R7 line released", r, 1);
        end
        quiet = 0;
        bus_stop();
        chk("R7 no drive after nack", quiet_bad, 0);
        do_read("R7 pointer not moved", 0, 1, 0, 8'h00);

        chk("R11 drive starts with scl low", r11_bad, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule